// File: doc/BRIEF.md
# Escaped Serial Command Parser

This block sits behind a UART receiver and turns its stream of bytes into register updates for an LED display and a bank of PWM meters. A thin escape layer comes first. A backslash makes the next byte literal, and a newline that is not escaped closes the current line. A command state machine then reads the bytes that survive this layer.

The state machine can do four things. It can set or clear one LED of a 32-bit frame. It can load a whole new frame into a back buffer and swap it to the front. It can write a level to one meter. It can answer a read request with a hex dump of the frame, which a small sequencer sends through a ready/valid byte output.

The parser has six states:

- `P_IDLE` reads the command byte.
  - 's' moves to `P_LED_NUM`.
  - 'b' moves to `P_BULK` and clears the byte counter.
  - 'a' moves to `P_MTR_IDX`.
  - 'r' starts a reply and stays in `P_IDLE`.
  - Any other byte is ignored.
- `P_LED_NUM` stores the LED number and moves to `P_LED_VAL`.
- `P_LED_VAL` applies the LED write and returns to `P_IDLE`.
- `P_BULK` writes one back-buffer byte per symbol. After the last byte it swaps the buffers and returns to `P_IDLE`.
- `P_MTR_IDX` stores the clamped meter index and moves to `P_MTR_LVL`.
- `P_MTR_LVL` fires the meter write and returns to `P_IDLE`.

From any state, an unescaped newline returns the parser to `P_IDLE`.

Top module: `esc_cmd_parser`

## Requirements
- R1: After reset, `frame_out` is zero in both banks, `out_valid` and `meter_we` are low, the parser is in `P_IDLE` and no escape is pending.
- R2: An input byte 0x5C arms the escape and produces no symbol. The next byte is passed on as a literal symbol, except that 0x6E becomes 0x0A.
- R3: An unescaped 0x0A produces no symbol and returns the parser to `P_IDLE` from any state.
- R4: Command 0x73 is followed by a number N and a value V. For N < 32, bit N mod 8 of frame byte N div 8 (byte k sits at `frame_out[8k+7:8k]`) is set if V is nonzero and cleared if V is zero. The write goes to the displayed bank and is visible one cycle after V is accepted.
- R5: A 0x73 command with N >= 32 leaves the frame unchanged.
- R6: Command 0x62 is followed by four symbols, which are written to back-buffer bytes 0 to 3 in order. On the fourth symbol the banks swap, and `frame_out` shows the new frame one cycle later.
- R7: A newline in the middle of a 0x62 load cancels it. No swap happens and `frame_out` is unchanged.
- R8: Command 0x61 is followed by an index I and a level L. One cycle after L is accepted, `meter_we` pulses for one cycle with `meter_level` = L and `meter_idx` = I. If I > METER_COUNT, `meter_idx` is 0 instead.
- R9: Command 0x72 queues a reply made of 'r' (0x72), then for each frame byte from 0 to 3 its low nibble and then its high nibble as uppercase ASCII hex, then 0x0A. The frame is captured at the moment the command is accepted.
- R10: A reply byte is held stable while `out_ready` is low. Input keeps being parsed during a reply, and a 0x72 that arrives while a reply is busy is dropped.
- R11: In `P_IDLE`, a symbol that is not one of the four command bytes has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | Reply byte present |
| out_ready | input | 1 | Consumer accepts reply byte |
| out_data | output | 8 | Reply byte |
| frame_out | output | 32 | Displayed frame, byte k at bits 8k+7:8k |
| meter_we | output | 1 | Meter write strobe |
| meter_idx | output | 3 | Meter index |
| meter_level | output | 8 | Meter level |

## Verification
The bench builds the block with its defaults: four frame bytes and METER_COUNT = 5. With these values, index 5 passes through unchanged, index 6 is forced to zero, and LED numbers 31 and 32 sit on either side of the frame boundary. A ten-byte reply is long enough for a stalling ready pattern to overlap LED writes and a second read request.

// File: rtl/esc_cmd_pkg.sv
`timescale 1ns/1ps
package esc_cmd_pkg;
    localparam logic [7:0] CH_BSL    = 8'h5C;
    localparam logic [7:0] CH_LF     = 8'h0A;
    localparam logic [7:0] CH_N      = 8'h6E;
    localparam logic [7:0] CMD_SET   = 8'h73;
    localparam logic [7:0] CMD_BULK  = 8'h62;
    localparam logic [7:0] CMD_METER = 8'h61;
    localparam logic [7:0] CMD_READ  = 8'h72;

    typedef enum logic [2:0] {
        P_IDLE, P_LED_NUM, P_LED_VAL, P_BULK, P_MTR_IDX, P_MTR_LVL
    } parse_state_t;

    function automatic logic [7:0] hex_char(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction
endpackage

// File: rtl/esc_unescape.sv
`timescale 1ns/1ps
module esc_unescape
    import esc_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       sym_valid,
    output logic [7:0] sym_data,
    output logic       line_end,
    output logic       esc_active
);
    logic esc_q, esc_d;

    always_ff @(posedge clk) begin
        if (!rst_n) esc_q <= 1'b0;
        else        esc_q <= esc_d;
    end

    always_comb begin
        esc_d     = esc_q;
        sym_valid = 1'b0;
        sym_data  = in_data;
        line_end  = 1'b0;
        if (in_valid) begin
            if (esc_q) begin
                esc_d     = 1'b0;
                sym_valid = 1'b1;
                if (in_data == CH_N) sym_data = CH_LF;
            end else if (in_data == CH_BSL) begin
                esc_d = 1'b1;
            end else if (in_data == CH_LF) begin
                line_end = 1'b1;
            end else begin
                sym_valid = 1'b1;
            end
        end
    end

    assign esc_active = esc_q;

    // R2
    esc_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && esc_q |=> !esc_q);
    // R2
    esc_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !esc_q && in_data == CH_BSL |-> !sym_valid && !line_end);
endmodule

// File: rtl/esc_frame_store.sv
`timescale 1ns/1ps
module esc_frame_store #(
    parameter int FRAME_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    led_we,
    input  logic [$clog2(FRAME_BYTES*8)-1:0] led_idx,
    input  logic                    led_on,
    input  logic                    bulk_we,
    input  logic [((FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1)-1:0] bulk_idx,
    input  logic [7:0]              bulk_data,
    input  logic                    swap,
    output logic [FRAME_BYTES*8-1:0] front
);
    localparam int FW = FRAME_BYTES * 8;

    logic [FW-1:0] bank [2];
    logic          sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank[0] <= '0;
            bank[1] <= '0;
            sel     <= 1'b0;
        end else begin
            if (led_we)  bank[sel][led_idx] <= led_on;
            if (bulk_we) bank[~sel][{bulk_idx, 3'b000} +: 8] <= bulk_data;
            if (swap)    sel <= ~sel;
        end
    end

    assign front = bank[sel];

    // R7
    front_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !led_we && !swap |=> $stable(front));
endmodule

// File: rtl/esc_reply_seq.sv
`timescale 1ns/1ps
module esc_reply_seq
    import esc_cmd_pkg::*;
#(
    parameter int FRAME_BYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [FRAME_BYTES*8-1:0] frame,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic [7:0]               out_data,
    output logic                     busy
);
    localparam int FW       = FRAME_BYTES * 8;
    localparam int REPLY_LEN = 2 * FRAME_BYTES + 2;
    localparam int POS_W    = $clog2(REPLY_LEN);
    localparam logic [POS_W-1:0] LAST = POS_W'(REPLY_LEN - 1);

    logic [POS_W-1:0] pos;
    logic [FW-1:0]    snap;
    logic [POS_W-1:0] nib_idx;
    logic [FW-1:0]    shifted;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            pos  <= '0;
            snap <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                pos  <= '0;
                snap <= frame;
            end
        end else if (out_ready) begin
            if (pos == LAST) busy <= 1'b0;
            else             pos  <= pos + 1'b1;
        end
    end

    always_comb begin
        nib_idx = pos - 1'b1;
        shifted = snap >> {nib_idx, 2'b00};
        if (pos == '0)       out_data = CMD_READ;
        else if (pos == LAST) out_data = CH_LF;
        else                 out_data = hex_char(shifted[3:0]);
    end

    assign out_valid = busy;

    // R10
    reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    // R9
    reply_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> out_valid && out_data == CMD_READ);
endmodule

// File: rtl/esc_cmd_parser.sv
`timescale 1ns/1ps
module esc_cmd_parser
    import esc_cmd_pkg::*;
#(
    parameter int FRAME_BYTES = 4,
    parameter int METER_COUNT = 5
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    input  logic [7:0]                           in_data,
    output logic                                 out_valid,
    input  logic                                 out_ready,
    output logic [7:0]                           out_data,
    output logic [FRAME_BYTES*8-1:0]             frame_out,
    output logic                                 meter_we,
    output logic [$clog2(METER_COUNT+1)-1:0]     meter_idx,
    output logic [7:0]                           meter_level
);
    localparam int FW     = FRAME_BYTES * 8;
    localparam int LIDX_W = $clog2(FW);
    localparam int BIDX_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
    localparam int MIDX_W = $clog2(METER_COUNT + 1);
    localparam logic [7:0]        LED_LIMIT = 8'(FW);
    localparam logic [7:0]        METER_MAX = 8'(METER_COUNT);
    localparam logic [BIDX_W-1:0] BULK_LAST = BIDX_W'(FRAME_BYTES - 1);

    logic       sym_valid, line_end, esc_active;
    logic [7:0] sym_data;

    parse_state_t      state_q, state_d;
    logic [7:0]        hold_q, hold_d;
    logic [BIDX_W-1:0] cnt_q, cnt_d;
    logic              led_we, bulk_we, swap, reply_start, mtr_fire, reply_busy;

    esc_unescape u_unesc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .sym_valid(sym_valid), .sym_data(sym_data), .line_end(line_end),
        .esc_active(esc_active)
    );

    esc_frame_store #(.FRAME_BYTES(FRAME_BYTES)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .led_we(led_we), .led_idx(hold_q[LIDX_W-1:0]), .led_on(|sym_data),
        .bulk_we(bulk_we), .bulk_idx(cnt_q), .bulk_data(sym_data),
        .swap(swap), .front(frame_out)
    );

    esc_reply_seq #(.FRAME_BYTES(FRAME_BYTES)) u_reply (
        .clk(clk), .rst_n(rst_n), .start(reply_start), .frame(frame_out),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .busy(reply_busy)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= P_IDLE;
            hold_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and actions
    always_comb begin
        state_d     = state_q;
        hold_d      = hold_q;
        cnt_d       = cnt_q;
        led_we      = 1'b0;
        bulk_we     = 1'b0;
        swap        = 1'b0;
        reply_start = 1'b0;
        mtr_fire    = 1'b0;
        if (line_end) begin
            state_d = P_IDLE;
        end else if (sym_valid) begin
            unique case (state_q)
                P_IDLE: begin
                    case (sym_data)
                        CMD_SET:   state_d = P_LED_NUM;
                        CMD_BULK:  begin cnt_d = '0; state_d = P_BULK; end
                        CMD_METER: state_d = P_MTR_IDX;
                        CMD_READ:  reply_start = 1'b1;
                        default:   ;
                    endcase
                end
                P_LED_NUM: begin
                    hold_d  = sym_data;
                    state_d = P_LED_VAL;
                end
                P_LED_VAL: begin
                    led_we  = (hold_q < LED_LIMIT);
                    state_d = P_IDLE;
                end
                P_BULK: begin
                    bulk_we = 1'b1;
                    if (cnt_q == BULK_LAST) begin
                        swap    = 1'b1;
                        state_d = P_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                P_MTR_IDX: begin
                    hold_d  = (sym_data > METER_MAX) ? 8'h00 : sym_data;
                    state_d = P_MTR_LVL;
                end
                P_MTR_LVL: begin
                    mtr_fire = 1'b1;
                    state_d  = P_IDLE;
                end
                default: state_d = P_IDLE;
            endcase
        end
    end

    // registered meter outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meter_we    <= 1'b0;
            meter_idx   <= '0;
            meter_level <= '0;
        end else begin
            meter_we <= mtr_fire;
            if (mtr_fire) begin
                meter_idx   <= hold_q[MIDX_W-1:0];
                meter_level <= sym_data;
            end
        end
    end

    // R3
    newline_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !esc_active && in_data == CH_LF |=> state_q == P_IDLE);
    // R8
    meter_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meter_we |-> meter_idx <= MIDX_W'(METER_COUNT));
    // R8
    meter_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meter_we |=> !meter_we);
    // R5
    frame_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(frame_out));
endmodule

// File: tb/tb_esc_cmd_parser.sv
`timescale 1ns/1ps
module tb_esc_cmd_parser;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_ready = 1'b1;
    logic       out_valid;
    logic [7:0] out_data;
    logic [31:0] frame_out;
    logic       meter_we;
    logic [2:0] meter_idx;
    logic [7:0] meter_level;

    esc_cmd_parser dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .frame_out(frame_out), .meter_we(meter_we), .meter_idx(meter_idx),
        .meter_level(meter_level)
    );

    always #2 clk = ~clk;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    done = 0;
    bit    live = 0;
    string cur_req = "R1";

    // reference model state
    bit [7:0] fb [2][4];
    bit       m_sel;
    bit       m_esc;
    int       m_state;
    int       m_hold;
    int       m_cnt;
    bit [7:0] exp_q [$];
    bit       exp_we;
    int       exp_idx;
    bit [7:0] exp_lvl;
    bit       pending_pop;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit [31:0] model_frame();
        bit [31:0] f;
        for (int k = 0; k < 4; k++) f[8*k +: 8] = fb[m_sel][k];
        return f;
    endfunction

    function automatic bit [7:0] hexc(input bit [3:0] n);
        return (n < 10) ? 8'(48 + n) : 8'(55 + n);
    endfunction

    // model: one step per clock from the inputs of that cycle
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int k = 0; k < 4; k++) fb[b][k] = 0;
            m_sel = 0; m_esc = 0; m_state = 0; m_hold = 0; m_cnt = 0;
            exp_q.delete(); exp_we = 0; exp_idx = 0; exp_lvl = 0;
        end else begin
            bit busy_before;
            bit sv, le;
            bit [7:0] s;
            busy_before = (exp_q.size() != 0);
            if (pending_pop && exp_q.size() != 0) void'(exp_q.pop_front());
            exp_we = 0;
            sv = 0; le = 0; s = in_data;
            if (in_valid) begin
                if (m_esc) begin
                    m_esc = 0; sv = 1;
                    if (in_data == 8'h6E) s = 8'h0A;
                end else if (in_data == 8'h5C) m_esc = 1;
                else if (in_data == 8'h0A) le = 1;
                else sv = 1;
            end
            if (le) m_state = 0;
            else if (sv) begin
                case (m_state)
                    0: begin
                        if (s == "s") m_state = 1;
                        else if (s == "b") begin m_cnt = 0; m_state = 3; end
                        else if (s == "a") m_state = 4;
                        else if (s == "r" && !busy_before) begin
                            bit [31:0] f;
                            f = model_frame();
                            exp_q.push_back("r");
                            for (int k = 0; k < 4; k++) begin
                                exp_q.push_back(hexc(f[8*k +: 4]));
                                exp_q.push_back(hexc(f[8*k+4 +: 4]));
                            end
                            exp_q.push_back(8'h0A);
                        end
                    end
                    1: begin m_hold = s; m_state = 2; end
                    2: begin
                        if (m_hold < 32) fb[m_sel][m_hold / 8][m_hold % 8] = (s != 0);
                        m_state = 0;
                    end
                    3: begin
                        fb[~m_sel][m_cnt] = s;
                        m_cnt++;
                        if (m_cnt == 4) begin m_sel = ~m_sel; m_state = 0; end
                    end
                    4: begin m_hold = (s > 5) ? 0 : s; m_state = 5; end
                    default: begin
                        exp_we = 1; exp_idx = m_hold; exp_lvl = s; m_state = 0;
                    end
                endcase
            end
        end
    end

    // compare on every clock, away from the edge
    always @(negedge clk) begin
        if (live && !done) begin
            chk(frame_out == model_frame(), cur_req, "frame_out", frame_out, model_frame());
            chk(meter_we == exp_we, "R8", "meter_we", meter_we, exp_we);
            if (exp_we && meter_we) begin
                chk(meter_idx == 3'(exp_idx), "R8", "meter_idx", meter_idx, exp_idx);
                chk(meter_level == exp_lvl, "R8", "meter_level", meter_level, exp_lvl);
            end
            chk(out_valid == (exp_q.size() != 0), "R9", "out_valid", out_valid, exp_q.size() != 0);
            if (out_valid && exp_q.size() != 0)
                chk(out_data == exp_q[0], "R10", "out_data", out_data, exp_q[0]);
        end
        pending_pop = out_valid && out_ready;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic put(input logic [7:0] b);
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
        end
    endtask

    task automatic led(input logic [7:0] num, input logic [7:0] val);
        put("s"); put(num); put(val);
    endtask

    initial begin
        idle(3);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(frame_out == 0, "R1", "frame_out", frame_out, 0);
        chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
        chk(meter_we == 0, "R1", "meter_we", meter_we, 0);
        live = 1;

        cur_req = "R4";
        led(0, 1); led(9, 8'hFF); led(31, 2); led(17, 1); idle(1);
        led(9, 0); idle(2);
        @(negedge clk);
        chk(frame_out == 32'h8002_0001, "R4", "frame after sets", frame_out, 32'h8002_0001);

        cur_req = "R5";
        led(32, 1); led(200, 1); idle(2);

        cur_req = "R2";
        put("s"); put(8'h5C); put("n"); put(8'h5C); put("n"); idle(2);
        put("s"); put(8'h5C); put(8'h5C); put(1); idle(2);
        @(negedge clk);
        chk(frame_out[10] == 1'b1, "R2", "escaped LED 10", frame_out[10], 1);

        cur_req = "R3";
        put("s"); put(5); put(8'h0A); put("s"); put(6); put(1); idle(2);
        @(negedge clk);
        chk(frame_out[6:5] == 2'b10, "R3", "LED 6/5 after newline", frame_out[6:5], 2'b10);

        cur_req = "R11";
        put("x"); put("Z"); put(8'h00); led(7, 1); idle(2);

        cur_req = "R6";
        put("b"); put(8'h12); put(8'h5C); put(8'h5C); put(8'hA5); put(8'h3C); idle(2);
        @(negedge clk);
        chk(frame_out == 32'h3CA5_5C12, "R6", "frame after bulk", frame_out, 32'h3CA5_5C12);
        put("b"); put(1); put(2); put(3); put(4); idle(2);

        cur_req = "R7";
        put("b"); put(8'hEE); put(8'hDD); put(8'h0A); idle(2);
        put("b"); put(8'hF0); put(8'h0F); put(8'h5C); put("n"); put(8'h77); idle(2);

        cur_req = "R8";
        put("a"); put(2); put(8'h80); idle(1);
        put("a"); put(5); put(8'h11); idle(1);
        put("a"); put(6); put(8'h22); idle(1);
        put("a"); put(200); put(8'h33); idle(2);

        cur_req = "R9";
        put("r"); idle(14);

        cur_req = "R10";
        out_ready = 1'b0;
        put("r"); idle(4);
        led(3, 1); put("r"); idle(3);
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            out_ready = 1'($urandom_range(0, 1));
        end
        out_ready = 1'b1;
        idle(14);
        put("r"); led(24, 1); idle(14);

        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule